// File: doc/BRIEF.md
# Diagonal Dynamic-Programming Cost Array for Stereo Scan-Lines

This block runs the forward pass of dynamic-programming stereo matching on one pair of rectified scan-lines. One left pixel and one right pixel enter per clock. A row of identical cells, one for each disparity in a fixed band `0 .. NUM_DISP-1`, all update together on that clock. Together they form one diagonal step of the disparity-space cost plane. Diagonal step `t` takes in left pixel `t`. Its cell for disparity `d` compares that pixel with right pixel `t-d`.

Each cell keeps a saturating accumulated cost. It takes the cheapest of three predecessors from the previous diagonal step: its own previous cost plus the match cost, the cell at `d-1` plus an occlusion penalty, or the cell at `d+1` plus the same penalty. The cell then records which predecessor it took as a 2-bit tag. The tags of all cells form one word. That word is written out through a memory write port, and its address is the diagonal index inside the line. A later backtracking pass, outside this block, reads the tags back to recover disparities.

Top module: `dpc_diag_array`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted pixel, `tag_we`, `tag_addr`, `tag_data` and `tag_last` are all zero.
- R2: Every clock with `pix_valid` high produces exactly one tag write on the next clock. The write address is 0 for a pixel with `pix_sol` high and is one more than the previous write address otherwise (modulo 2^ADDR_W).
- R3: The match cost of the cell for disparity d is |left(t) - right(t-d)|. A right pixel from before the current line start counts as intensity 0.
- R4: Each cell chooses the smallest candidate. Ties go to match, then to the lower neighbour, then to the upper neighbour. The tag field for disparity d sits at `tag_data[2d+1:2d]`, coded 00 = match (same d), 01 = left occlusion (from d-1), 10 = right occlusion (from d+1). Code 11 never appears.
- R5: A neighbour outside the band counts as maximum cost. The cell for d=0 never writes 01, and the cell for d=NUM_DISP-1 never writes 10.
- R6: Accumulated costs and candidate sums saturate at 2^COST_W-1 and never wrap.
- R7: A pixel with `pix_sol` high treats every previous cost as zero and the whole right-pixel history as zero. This holds even if the previous line was never closed.
- R8: A clock with `pix_valid` low writes nothing and leaves costs, right history and the address count unchanged.
- R9: `tag_last` on a write equals the `pix_eol` flag of the pixel that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel pair present this clock |
| pix_sol | input | 1 | Pixel pair is the first of a scan-line |
| pix_eol | input | 1 | Pixel pair is the last of a scan-line |
| pix_left | input | PIX_W | Left-image intensity |
| pix_right | input | PIX_W | Right-image intensity |
| tag_we | output | 1 | Tag word write strobe |
| tag_addr | output | ADDR_W | Diagonal index within the line |
| tag_data | output | 2*NUM_DISP | One 2-bit transition tag per disparity |
| tag_last | output | 1 | Write belongs to the last pixel of the line |

## Verification
The bench pushes lines that contain both exact ties and long runs of large differences. A wrong tie order or a missing saturation would show up as wrong tags, and a wrapped cost would make a cell that has already saturated look cheap again. It restarts a line in the middle with no line end, and it sends a line of a single pixel. A design that kept old costs or old right pixels across a restart would give tags that differ from those of a fresh line. Idle gaps are placed inside the lines, and a design that advanced its history or address during a gap would shift every later comparison. Gradient ramps push the cheapest path against both ends of the band, which catches an edge cell that takes an out-of-band neighbour.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
   typedef enum logic [1:0] {
      TAG_MATCH = 2'b00,
      TAG_OCC_L = 2'b01,
      TAG_OCC_R = 2'b10
   } dpc_tag_e;
endpackage

// File: rtl/dpc_rwin.sv
// Right-pixel window: win[k] is the right pixel from k accepted steps ago.
module dpc_rwin #(
   parameter int PIX_W = 8,
   parameter int DEPTH = 65
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        adv,
   input  logic                        restart,
   input  logic [PIX_W-1:0]            pix_in,
   output logic [DEPTH-1:0][PIX_W-1:0] win
);
   assign win[0] = pix_in;

   generate
      if (DEPTH > 1) begin : g_hist
         logic [DEPTH-2:0][PIX_W-1:0] hist_q;
         for (genvar k = 1; k < DEPTH; k++) begin : g_tap
            assign win[k] = restart ? '0 : hist_q[k-1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hist_q <= '0;
            end else if (adv) begin
               for (int k = 0; k < DEPTH-1; k++) begin
                  hist_q[k] <= win[k];
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dpc_diag_ctr.sv
// Diagonal index within the current scan-line.
module dpc_diag_ctr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              restart,
   output logic [ADDR_W-1:0] idx
);
   logic [ADDR_W-1:0] cnt_q;

   assign idx = restart ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/dpc_cell.sv
// One disparity cell: three saturating candidates, priority minimum, cost register.
module dpc_cell
   import dpc_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int COST_W  = 12,
   parameter int OCC_PEN = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [COST_W-1:0] prev_own,
   input  logic [COST_W-1:0] prev_lo,
   input  logic [COST_W-1:0] prev_hi,
   input  logic [PIX_W-1:0]  pix_l,
   input  logic [PIX_W-1:0]  pix_r,
   output logic [COST_W-1:0] cost_q,
   output dpc_tag_e          tag
);
   localparam int           SUM_W = COST_W + 1;
   localparam logic [SUM_W-1:0] CMAX = {1'b0, {COST_W{1'b1}}};
   localparam logic [SUM_W-1:0] PEN  = SUM_W'(OCC_PEN);

   function automatic logic [SUM_W-1:0] sat(input logic [SUM_W-1:0] x);
      return (x > CMAX) ? CMAX : x;
   endfunction

   logic [PIX_W-1:0]  diff;
   logic [SUM_W-1:0]  cand_m, cand_l, cand_r, best;

   assign diff   = (pix_l >= pix_r) ? (pix_l - pix_r) : (pix_r - pix_l);
   assign cand_m = sat({1'b0, prev_own} + SUM_W'(diff));
   assign cand_l = sat({1'b0, prev_lo} + PEN);
   assign cand_r = sat({1'b0, prev_hi} + PEN);

   always_comb begin
      if (cand_m <= cand_l && cand_m <= cand_r) begin
         tag  = TAG_MATCH;
         best = cand_m;
      end else if (cand_l <= cand_r) begin
         tag  = TAG_OCC_L;
         best = cand_l;
      end else begin
         tag  = TAG_OCC_R;
         best = cand_r;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cost_q <= '0;
      end else if (adv) begin
         cost_q <= best[COST_W-1:0];
      end
   end
endmodule

// File: rtl/dpc_diag_array.sv
module dpc_diag_array
   import dpc_pkg::*;
#(
   parameter int  PIX_W    = 8,
   parameter int  NUM_DISP = 65,
   parameter int  COST_W   = 12,
   parameter int  OCC_PEN  = 20,
   parameter int  MAX_LINE = 640,
   localparam int ADDR_W   = $clog2(MAX_LINE),
   localparam int TAG_W    = 2 * NUM_DISP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_valid,
   input  logic              pix_sol,
   input  logic              pix_eol,
   input  logic [PIX_W-1:0]  pix_left,
   input  logic [PIX_W-1:0]  pix_right,
   output logic              tag_we,
   output logic [ADDR_W-1:0] tag_addr,
   output logic [TAG_W-1:0]  tag_data,
   output logic              tag_last
);
   if (NUM_DISP < 2) begin : g_chk_disp
      $error("NUM_DISP must be at least 2");
   end
   if (COST_W <= PIX_W) begin : g_chk_cost
      $error("COST_W must exceed PIX_W");
   end
   if (OCC_PEN < 0 || OCC_PEN >= (1 << COST_W)) begin : g_chk_pen
      $error("OCC_PEN must fit in COST_W bits");
   end
   if (MAX_LINE < 2) begin : g_chk_line
      $error("MAX_LINE must be at least 2");
   end

   localparam logic [COST_W-1:0] OUT_OF_BAND = '1;

   logic                           restart;
   logic [NUM_DISP-1:0][PIX_W-1:0] rwin;
   logic [ADDR_W-1:0]              diag_idx;
   logic [COST_W-1:0]              cost_q   [NUM_DISP];
   logic [COST_W-1:0]              cost_prv [NUM_DISP];
   logic [TAG_W-1:0]               tag_word;

   assign restart = pix_valid & pix_sol;

   dpc_rwin #(.PIX_W(PIX_W), .DEPTH(NUM_DISP)) u_rwin (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (pix_valid),
      .restart (restart),
      .pix_in  (pix_right),
      .win     (rwin)
   );

   dpc_diag_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (pix_valid),
      .restart (restart),
      .idx     (diag_idx)
   );

   generate
      for (genvar d = 0; d < NUM_DISP; d++) begin : g_cell
         logic [COST_W-1:0] nb_lo, nb_hi;
         dpc_tag_e          cell_tag;

         assign cost_prv[d] = restart ? '0 : cost_q[d];

         if (d == 0) begin : g_lo_edge
            assign nb_lo = OUT_OF_BAND;
         end else begin : g_lo_in
            assign nb_lo = cost_prv[d-1];
         end

         if (d == NUM_DISP-1) begin : g_hi_edge
            assign nb_hi = OUT_OF_BAND;
         end else begin : g_hi_in
            assign nb_hi = cost_prv[d+1];
         end

         dpc_cell #(.PIX_W(PIX_W), .COST_W(COST_W), .OCC_PEN(OCC_PEN)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (pix_valid),
            .prev_own (cost_prv[d]),
            .prev_lo  (nb_lo),
            .prev_hi  (nb_hi),
            .pix_l    (pix_left),
            .pix_r    (rwin[d]),
            .cost_q   (cost_q[d]),
            .tag      (cell_tag)
         );

         assign tag_word[2*d +: 2] = cell_tag;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_we   <= 1'b0;
         tag_addr <= '0;
         tag_data <= '0;
         tag_last <= 1'b0;
      end else begin
         tag_we <= pix_valid;
         if (pix_valid) begin
            tag_addr <= diag_idx;
            tag_data <= tag_word;
            tag_last <= pix_eol;
         end
      end
   end
endmodule

// File: rtl/dpc_diag_array_chk.sv
module dpc_diag_array_chk #(
   parameter int NUM_DISP = 65,
   parameter int ADDR_W   = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  pix_valid,
   input logic                  pix_sol,
   input logic                  pix_eol,
   input logic                  tag_we,
   input logic [ADDR_W-1:0]     tag_addr,
   input logic [2*NUM_DISP-1:0] tag_data,
   input logic                  tag_last
);
   logic wrote_q;

   always_ff @(posedge clk) begin
      if (!rst_n) wrote_q <= 1'b0;
      else if (tag_we) wrote_q <= 1'b1;
   end

   AST_WE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> tag_we); // R2
   AST_ADDR_SOL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_sol) |=> (tag_addr == '0)); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_sol && wrote_q) |=> (tag_addr == $past(tag_addr) + 1'b1)); // R2
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !tag_we); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> ($stable(tag_addr) && $stable(tag_data))); // R8
   AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> (tag_last == $past(pix_eol))); // R9
   AST_EDGE_LO: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |-> (tag_data[1:0] != 2'b01)); // R5
   AST_EDGE_HI: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |-> (tag_data[2*NUM_DISP-1 -: 2] != 2'b10)); // R5

   generate
      for (genvar d = 0; d < NUM_DISP; d++) begin : g_code
         AST_TAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            tag_we |-> (tag_data[2*d +: 2] != 2'b11)); // R4
      end
   endgenerate
endmodule

bind dpc_diag_array dpc_diag_array_chk #(.NUM_DISP(NUM_DISP), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_valid (pix_valid),
   .pix_sol   (pix_sol),
   .pix_eol   (pix_eol),
   .tag_we    (tag_we),
   .tag_addr  (tag_addr),
   .tag_data  (tag_data),
   .tag_last  (tag_last)
);

// File: tb/tb_dpc_diag_array.sv
`timescale 1ns/1ps
module tb_dpc_diag_array;
   localparam int PW   = 8;
   localparam int D    = 8;
   localparam int CW   = 10;
   localparam int PEN  = 20;
   localparam int ML   = 128;
   localparam int AW   = $clog2(ML);
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pix_valid = 1'b0, pix_sol = 1'b0, pix_eol = 1'b0;
   logic [PW-1:0] pix_left = '0, pix_right = '0;
   logic          tag_we, tag_last;
   logic [AW-1:0] tag_addr;
   logic [2*D-1:0] tag_data;

   always #2.5 clk = ~clk;

   dpc_diag_array #(.PIX_W(PW), .NUM_DISP(D), .COST_W(CW), .OCC_PEN(PEN), .MAX_LINE(ML)) dut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol),
      .pix_left(pix_left), .pix_right(pix_right), .tag_we(tag_we), .tag_addr(tag_addr),
      .tag_data(tag_data), .tag_last(tag_last));

   int n_chk = 0, n_fail = 0;
   string phase = "R1";

   // behavioural reference state
   int cost_m [D];
   int rhist  [D];
   int cnt_m  = 0;
   bit          exp_we = 0, exp_last = 0;
   int          exp_addr = 0;
   logic [2*D-1:0] exp_data = '0;
   bit [31:0] lcg = 32'h1234_5678;

   function automatic int sat(int x);
      return (x > CMAX) ? CMAX : x;
   endfunction

   function automatic int rnd();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return int'(lcg[23:16]);
   endfunction

   task automatic chk(bit ok, string what, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s (phase %s) act=%0h exp=%0h", req, what, phase, act, exp);
      end
   endtask

   task automatic compare();
      chk(tag_we === exp_we, "tag_we", "R2/R8", tag_we, exp_we);
      if (exp_we) begin
         chk(tag_addr === AW'(exp_addr), "tag_addr", "R2", tag_addr, exp_addr);
         chk(tag_data === exp_data, "tag_data", "R4", tag_data, exp_data);
         chk(tag_last === exp_last, "tag_last", "R9", tag_last, exp_last);
      end
   endtask

   task automatic model(bit s, bit e, int l, int r);
      int nc [D];
      if (s) begin
         for (int d = 0; d < D; d++) begin cost_m[d] = 0; rhist[d] = 0; end
         cnt_m = 0;
      end
      for (int d = 0; d < D; d++) begin
         int rp, m, cm, cl, cr;
         rp = (d == 0) ? r : rhist[d-1];
         m  = (l > rp) ? l - rp : rp - l;          // R3
         cm = sat(cost_m[d] + m);                    // R6
         cl = (d > 0)   ? sat(cost_m[d-1] + PEN) : CMAX;  // R5
         cr = (d < D-1) ? sat(cost_m[d+1] + PEN) : CMAX;
         if (cm <= cl && cm <= cr) begin nc[d] = cm; exp_data[2*d +: 2] = 2'b00; end
         else if (cl <= cr)        begin nc[d] = cl; exp_data[2*d +: 2] = 2'b01; end
         else                      begin nc[d] = cr; exp_data[2*d +: 2] = 2'b10; end
      end
      for (int d = 0; d < D; d++) cost_m[d] = nc[d];
      for (int k = D-1; k > 0; k--) rhist[k] = rhist[k-1];
      rhist[0] = r;
      exp_addr = cnt_m;
      cnt_m    = (cnt_m + 1) % (1 << AW);
      exp_last = e;
   endtask

   task automatic step(bit v, bit s, bit e, int l, int r);
      @(negedge clk);
      compare();
      pix_valid = v; pix_sol = s; pix_eol = e;
      pix_left = PW'(l); pix_right = PW'(r);
      exp_we = v;
      if (v) model(s, e, l, r);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, rnd(), rnd());   // R8: junk pixels ignored
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int lv [64];
      for (int d = 0; d < D; d++) begin cost_m[d] = 0; rhist[d] = 0; end
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(tag_we === 1'b0 && tag_addr === '0 && tag_data === '0 && tag_last === 1'b0,
          "reset outputs", "R1", {tag_we, tag_last, tag_data}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tag_we === 1'b0 && tag_data === '0, "after reset", "R1", tag_data, 0);

      // R2 R4 R8: random line with idle gaps
      phase = "R2_R4_R8";
      for (int t = 0; t < 48; t++) begin
         step(1, t == 0, t == 47, rnd(), rnd());
         if (t % 5 == 4) idle(2);
      end
      idle(3);

      // R3: right image shifted by 3 pixels
      phase = "R3";
      for (int i = 0; i < 64; i++) lv[i] = rnd();
      for (int t = 0; t < 40; t++) step(1, t == 0, t == 39, lv[t + 3], lv[t]);
      idle(2);

      // R4: flat image, exact ties everywhere
      phase = "R4_ties";
      for (int t = 0; t < 20; t++) step(1, t == 0, t == 19, 100, 100);
      for (int t = 0; t < 20; t++) step(1, t == 0, t == 19, 100 + (t % 2) * PEN, 100);

      // R5: ramps that pull the path to both ends of the band
      phase = "R5";
      for (int t = 0; t < 30; t++) step(1, t == 0, t == 29, (t * 9) % 256, (t * 9 + 40) % 256);
      for (int t = 0; t < 30; t++) step(1, t == 0, t == 29, 255 - (t * 7) % 256, (t * 13) % 256);

      // R6: large differences until every cost saturates
      phase = "R6";
      for (int t = 0; t < 100; t++) step(1, t == 0, t == 99, 255, (t > 80) ? 255 : 0);
      idle(1);

      // R7: restart mid-line without an end flag, then a one-pixel line
      phase = "R7";
      for (int t = 0; t < 12; t++) step(1, t == 0, 1'b0, rnd(), rnd());
      for (int t = 0; t < 20; t++) step(1, t == 0, t == 19, rnd(), rnd());
      step(1, 1, 1, 77, 200);
      step(1, 1, 1, 0, 255);

      // R2: address wraps on an overlong line
      phase = "R2_wrap";
      for (int t = 0; t < (1 << AW) + 4; t++) step(1, t == 0, 1'b0, rnd(), rnd());
      idle(2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule